// File: doc/BRIEF.md
# Dual-Level Carrier Timer with Capture

This block is an 8-bit down-counting timer that runs in one of two modes. In transmit mode it produces a square-ish waveform. The low phase and the high phase take their lengths from two separate hold registers, so the block can generate a carrier or a pulse train with an arbitrary duty cycle. The waveform either repeats (modulo-N) or stops after one timeout (single-pass). In demodulation mode the same counter measures the time from one qualifying edge of a filtered input to the next. It stores each measurement in a capture register and restarts from all ones for the next interval.

Software reaches the block through a small register port, with a write strobe and a combinational read address. A prescaled clock enable paces the counter. One control bit chooses whether the output pin carries the timer waveform or ordinary port data. Two interrupt lines pulse on timeout and on capture.

Top module: `carrier_timer`

## Requirements
- R1: After reset every readable register (addresses 0 to 4) reads 0, both interrupt lines are low, and `pinOut` follows `portData`.
- R2: Register map: address 0 is control A, 1 is control B, 2 is the low-phase hold, 3 is the high-phase hold, and 4 is the read-only capture register. In control A, bit 0 is enable, bit 1 selects single-pass, bit 2 is timeout status, bit 3 unmasks the timeout interrupt, bit 4 unmasks the capture interrupt and bit 5 routes the timer to the pin. In control B, bit 0 selects transmit (1) or demodulation (0), bit 1 is the initial output level, bits 3:2 select the edge and bits 6:4 set the filter width. A write that raises enable from 0 sets the output to the initial level and loads the hold register for that level. Apart from that start, the output changes only on a timeout.
- R3: In modulo-N transmit mode the output toggles on each timeout and the counter reloads from the hold of the new level. Each phase therefore lasts hold+1 counted ticks.
- R4: In single-pass transmit mode the first timeout toggles the output, then clears the enable bit. The output then holds its level and no further events occur.
- R5: Every timeout sets the status bit (control A bit 2). Writing 1 there clears it, writing 0 leaves it unchanged, and a timeout in the same cycle wins over the clear.
- R6: `timeoutIrq` is high for one cycle, in the cycle after a timeout, only when control A bit 3 is set. With the mask clear the status bit still sets.
- R7: The counter moves only in cycles where `tickEn` is high. Starting and edge handling do not wait for a tick.
- R8: In demodulation mode the counter stays idle after enable until the first qualifying edge. That edge loads 0xFF without a capture. Each later edge, D cycles after the previous one with ticks every cycle, stores 256-D in the capture register, reloads 0xFF and, when control A bit 4 is set, pulses `captIrq` for one cycle.
- R9: Edge select: 00 none, 01 rising only, 10 falling only, 11 both. Edges that are not selected are ignored.
- R10: The filtered input takes a new raw level only after the raw input has differed from it for W+1 consecutive clocks, with W the filter width. An edge is acted on one clock after the filtered input changes.
- R11: In demodulation mode, if the count reaches zero and a further tick arrives before a new edge, the block sets the status bit, raises the timeout interrupt when it is unmasked, reloads 0xFF and keeps running. With ticks every cycle this happens 256 cycles after the last edge.
- R12: With control A bit 5 set, `pinOut` carries the timer output; with it clear, `pinOut` carries `portData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | Prescaled count enable |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 8 | Register write data |
| rdAddr | input | 3 | Register read address |
| rdData | output | 8 | Register read data (combinational) |
| sigIn | input | 1 | Raw input measured in demodulation mode |
| portData | input | 1 | Ordinary port data for the pin |
| pinOut | output | 1 | Pin level: timer output or port data |
| timeoutIrq | output | 1 | Timeout interrupt pulse |
| captIrq | output | 1 | Capture interrupt pulse |

## Verification
The hardest situation to reach is the glitch filter rejecting a short pulse, because a rejected pulse leaves no trace at the ports. The stimulus therefore arms the measurement, applies a pulse one clock shorter than the filter needs, and then applies a real rising edge. If the glitch had been taken as the first edge, the real edge would produce an early capture and a wrong captured count. The bench checks that no capture appears and that the later interval is measured exactly. The demodulation timeout also needs a long quiet period of 256 ticks after the last edge. The bench waits through it and checks the interrupt in the exact cycle it is due.

// File: rtl/ctimer_pkg.sv
`timescale 1ns/1ps
package ctimer_pkg;
  // register addresses
  localparam int ADR_CTLA = 0;
  localparam int ADR_CTLB = 1;
  localparam int ADR_LOW  = 2;
  localparam int ADR_HIGH = 3;
  localparam int ADR_CAPT = 4;

  // control A fields
  localparam int A_EN     = 0;
  localparam int A_SINGLE = 1;
  localparam int A_STAT   = 2;
  localparam int A_TMASK  = 3;
  localparam int A_CMASK  = 4;
  localparam int A_ROUTE  = 5;

  // control B fields
  localparam int B_TX     = 0;
  localparam int B_INIT   = 1;
  localparam int B_EDGE   = 2;
  localparam int B_FILT   = 4;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic start;  // enable rising by a register write
    logic run;    // enable bit level
  } ctl_stb_t;
endpackage

// File: rtl/ctimer_ctrl.sv
`timescale 1ns/1ps
module ctimer_ctrl
  import ctimer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter int FILT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              timeoutEv,
  input  logic              captureEv,
  input  logic [DATA_W-1:0] captureVal,
  output ctl_stb_t          stb,
  output logic              txMode,
  output logic              initLvl,
  output edge_sel_e         edgeSel,
  output logic [FILT_W-1:0] filtW,
  output logic [DATA_W-1:0] lowHold,
  output logic [DATA_W-1:0] highHold,
  output logic              routeEn,
  output logic              timeoutIrq,
  output logic              captIrq
);
  localparam logic [ADDR_W-1:0] AdrA    = ADDR_W'(ADR_CTLA);
  localparam logic [ADDR_W-1:0] AdrB    = ADDR_W'(ADR_CTLB);
  localparam logic [ADDR_W-1:0] AdrLow  = ADDR_W'(ADR_LOW);
  localparam logic [ADDR_W-1:0] AdrHigh = ADDR_W'(ADR_HIGH);
  localparam logic [ADDR_W-1:0] AdrCapt = ADDR_W'(ADR_CAPT);

  logic enable, single, status, tMask, cMask;
  logic wrA, wrB;

  assign wrA = wrEn && (wrAddr == AdrA);
  assign wrB = wrEn && (wrAddr == AdrB);

  assign stb.start = wrA && wrData[A_EN] && !enable;
  assign stb.run   = enable;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable     <= 1'b0;
      single     <= 1'b0;
      status     <= 1'b0;
      tMask      <= 1'b0;
      cMask      <= 1'b0;
      routeEn    <= 1'b0;
      txMode     <= 1'b0;
      initLvl    <= 1'b0;
      edgeSel    <= EDGE_NONE;
      filtW      <= '0;
      lowHold    <= '0;
      highHold   <= '0;
      timeoutIrq <= 1'b0;
      captIrq    <= 1'b0;
    end else begin
      timeoutIrq <= timeoutEv && tMask;
      captIrq    <= captureEv && cMask;

      if (timeoutEv)
        status <= 1'b1;
      else if (wrA && wrData[A_STAT])
        status <= 1'b0;

      if (wrA) begin
        enable  <= wrData[A_EN];
        single  <= wrData[A_SINGLE];
        tMask   <= wrData[A_TMASK];
        cMask   <= wrData[A_CMASK];
        routeEn <= wrData[A_ROUTE];
      end else if (timeoutEv && txMode && single) begin
        enable  <= 1'b0;
      end

      if (wrB) begin
        txMode  <= wrData[B_TX];
        initLvl <= wrData[B_INIT];
        edgeSel <= edge_sel_e'(wrData[B_EDGE +: 2]);
        filtW   <= wrData[B_FILT +: FILT_W];
      end

      if (wrEn && (wrAddr == AdrLow))  lowHold  <= wrData;
      if (wrEn && (wrAddr == AdrHigh)) highHold <= wrData;
    end
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      AdrA: begin
        rdData[A_EN]     = enable;
        rdData[A_SINGLE] = single;
        rdData[A_STAT]   = status;
        rdData[A_TMASK]  = tMask;
        rdData[A_CMASK]  = cMask;
        rdData[A_ROUTE]  = routeEn;
      end
      AdrB: begin
        rdData[B_TX]            = txMode;
        rdData[B_INIT]          = initLvl;
        rdData[B_EDGE +: 2]     = edgeSel;
        rdData[B_FILT +: FILT_W] = filtW;
      end
      AdrLow:  rdData = lowHold;
      AdrHigh: rdData = highHold;
      AdrCapt: rdData = captureVal;
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/ctimer_dpath.sv
`timescale 1ns/1ps
module ctimer_dpath
  import ctimer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int FILT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              rawIn,
  input  ctl_stb_t          stb,
  input  logic              txMode,
  input  logic              initLvl,
  input  edge_sel_e         edgeSel,
  input  logic [FILT_W-1:0] filtW,
  input  logic [DATA_W-1:0] lowHold,
  input  logic [DATA_W-1:0] highHold,
  output logic              timerOut,
  output logic              timeoutEv,
  output logic              captureEv,
  output logic [DATA_W-1:0] captureVal
);
  localparam logic [DATA_W-1:0] CntFull = '1;

  logic [DATA_W-1:0] cnt;
  logic [FILT_W-1:0] fCnt;
  logic fIn, fPrev, running;
  logic riseDet, fallDet, qualEdge;
  logic active, demodEdge, counting;

  // glitch qualifier: raw must differ for filtW+1 clocks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fIn   <= 1'b0;
      fPrev <= 1'b0;
      fCnt  <= '0;
    end else begin
      fPrev <= fIn;
      if (rawIn == fIn) begin
        fCnt <= '0;
      end else if (fCnt == filtW) begin
        fIn  <= rawIn;
        fCnt <= '0;
      end else begin
        fCnt <= fCnt + 1'b1;
      end
    end
  end

  assign riseDet = fIn && !fPrev;
  assign fallDet = !fIn && fPrev;

  always_comb begin
    case (edgeSel)
      EDGE_RISE: qualEdge = riseDet;
      EDGE_FALL: qualEdge = fallDet;
      EDGE_BOTH: qualEdge = riseDet || fallDet;
      default:   qualEdge = 1'b0;
    endcase
  end

  assign active    = stb.run && !stb.start;
  assign demodEdge = active && !txMode && qualEdge;
  assign captureEv = demodEdge && running;
  assign counting  = active && (txMode || running) && tickEn;
  assign timeoutEv = counting && (cnt == '0) && !demodEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt        <= '0;
      timerOut   <= 1'b0;
      running    <= 1'b0;
      captureVal <= '0;
    end else if (stb.start) begin
      running <= txMode;
      if (txMode) begin
        timerOut <= initLvl;
        cnt      <= initLvl ? highHold : lowHold;
      end else begin
        cnt      <= CntFull;
      end
    end else if (demodEdge) begin
      running <= 1'b1;
      cnt     <= CntFull;
      if (running) captureVal <= cnt;
    end else if (timeoutEv) begin
      if (txMode) begin
        timerOut <= !timerOut;
        cnt      <= timerOut ? lowHold : highHold;
      end else begin
        cnt      <= CntFull;
      end
    end else if (counting) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/carrier_timer.sv
`timescale 1ns/1ps
module carrier_timer
  import ctimer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter int FILT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              sigIn,
  input  logic              portData,
  output logic              pinOut,
  output logic              timeoutIrq,
  output logic              captIrq
);
  ctl_stb_t          stb;
  logic              txMode, initLvl, routeEn, timerOut;
  logic              timeoutEv, captureEv;
  edge_sel_e         edgeSel;
  logic [FILT_W-1:0] filtW;
  logic [DATA_W-1:0] lowHold, highHold, captureVal;

  ctimer_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .FILT_W(FILT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .timeoutEv(timeoutEv), .captureEv(captureEv),
    .captureVal(captureVal), .stb(stb), .txMode(txMode), .initLvl(initLvl),
    .edgeSel(edgeSel), .filtW(filtW), .lowHold(lowHold), .highHold(highHold),
    .routeEn(routeEn), .timeoutIrq(timeoutIrq), .captIrq(captIrq)
  );

  ctimer_dpath #(.DATA_W(DATA_W), .FILT_W(FILT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .rawIn(sigIn), .stb(stb),
    .txMode(txMode), .initLvl(initLvl), .edgeSel(edgeSel), .filtW(filtW),
    .lowHold(lowHold), .highHold(highHold), .timerOut(timerOut),
    .timeoutEv(timeoutEv), .captureEv(captureEv), .captureVal(captureVal)
  );

  assign pinOut = routeEn ? timerOut : portData;
endmodule

// File: rtl/ctimer_checker.sv
`timescale 1ns/1ps
module ctimer_checker (
  input logic clk,
  input logic rstN,
  input logic startStb,
  input logic runEn,
  input logic txMode,
  input logic timerOut,
  input logic timeoutEv,
  input logic captureEv,
  input logic timeoutIrq,
  input logic captIrq
);
  // R2: output level moves only on start or timeout
  assert_out_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(timeoutEv) && !$past(startStb)) |-> $stable(timerOut))
    else $error("timer output changed without start or timeout");

  // R3: a transmit timeout flips the output
  assert_toggle_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(timeoutEv && txMode && !startStb)) |-> (timerOut != $past(timerOut)))
    else $error("transmit timeout did not toggle output");

  // R4: no events while stopped
  assert_stopped_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |-> (!timeoutEv && !captureEv))
    else $error("event while disabled");

  // R6: timeout interrupt only after a timeout
  assert_tirq_src_R6: assert property (@(posedge clk) disable iff (!rstN)
    timeoutIrq |-> $past(timeoutEv))
    else $error("timeout interrupt without timeout");

  // R8: captures happen only in demodulation mode and drive the interrupt
  assert_capt_mode_R8: assert property (@(posedge clk) disable iff (!rstN)
    captureEv |-> !txMode)
    else $error("capture in transmit mode");

  assert_cirq_src_R8: assert property (@(posedge clk) disable iff (!rstN)
    captIrq |-> $past(captureEv))
    else $error("capture interrupt without capture");
endmodule

bind carrier_timer ctimer_checker u_chk (
  .clk(clk), .rstN(rstN), .startStb(stb.start), .runEn(stb.run),
  .txMode(txMode), .timerOut(timerOut), .timeoutEv(timeoutEv),
  .captureEv(captureEv), .timeoutIrq(timeoutIrq), .captIrq(captIrq)
);

// File: tb/sim_carrier_timer.sv
`timescale 1ns/1ps
module sim_carrier_timer;
  localparam int DW = 8;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b1;
  logic wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [AW-1:0] rdAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic sigIn = 1'b0;
  logic portData = 1'b0;
  logic [DW-1:0] rdData;
  logic pinOut, timeoutIrq, captIrq;

  int cyc = 0;
  int nChk = 0;
  int nBad = 0;
  int tickMode = 0;
  bit finished = 0;

  typedef struct {
    int    due;
    int    sig;   // 0 pinOut, 1 timeoutIrq, 2 captIrq
    int    val;
    string req;
  } exp_t;
  exp_t sb[$];

  carrier_timer u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .sigIn(sigIn),
    .portData(portData), .pinOut(pinOut), .timeoutIrq(timeoutIrq), .captIrq(captIrq)
  );

  always #2.5 clk = ~clk;

  task automatic check(string req, string what, int act, int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s cycle %0d: actual=%0d expected=%0d", req, what, cyc, act, exp);
    end
  endtask

  task automatic expectAt(int due, int sig, int val, string req);
    exp_t e;
    e.due = due; e.sig = sig; e.val = val; e.req = req;
    sb.push_back(e);
  endtask

  // monitor: compares due items just after each rising edge
  initial forever begin
    @(posedge clk);
    #1;
    cyc++;
    for (int i = 0; i < sb.size(); ) begin
      if (sb[i].due == cyc) begin
        case (sb[i].sig)
          0: check(sb[i].req, "pinOut", int'(pinOut), sb[i].val);
          1: check(sb[i].req, "timeoutIrq", int'(timeoutIrq), sb[i].val);
          default: check(sb[i].req, "captIrq", int'(captIrq), sb[i].val);
        endcase
        sb.delete(i);
      end else begin
        i++;
      end
    end
  end

  // tick pacing: mode 1 ticks only on even edges
  initial forever begin
    @(negedge clk);
    tickEn = (tickMode == 0) ? 1'b1 : (((cyc + 1) % 2) == 0);
  end

  task automatic regWrite(int a, int d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = AW'(a); wrData = DW'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readMask(int a, int mask, int exp, string req);
    @(negedge clk);
    rdAddr = AW'(a);
    #1;
    check(req, "rdData", int'(rdData) & mask, exp);
  endtask

  task automatic waitCyc(int c);
    while (cyc < c) @(negedge clk);
  endtask

  // expected transmit waveform from the requirements
  task automatic txModel(int e0, int init, int low, int high, int n, int mask,
                         int gated, int single, string reqOut, string reqIrq);
    int lvl = init;
    int c = init ? high : low;
    int stopped = 0;
    for (int t = 1; t <= n; t++) begin
      int e = e0 + t;
      int to = 0;
      if (!stopped && (!gated || (e % 2) == 0)) begin
        if (c == 0) begin
          to = 1;
          lvl = 1 - lvl;
          c = lvl ? high : low;
          if (single) stopped = 1;
        end else begin
          c--;
        end
      end
      expectAt(e, 0, lvl, reqOut);
      expectAt(e, 1, to & mask, reqIrq);
    end
  endtask

  initial begin
    #(5 * 150000);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

  initial begin
    int e0, c0, c1, c2;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 5; a++) readMask(a, 255, 0, "R1");
    check("R1", "timeoutIrq", int'(timeoutIrq), 0);
    check("R1", "captIrq", int'(captIrq), 0);
    check("R1", "pinOut", int'(pinOut), 0);
    portData = 1'b1; #1;
    check("R12", "pinOut follows portData", int'(pinOut), 1);
    portData = 1'b0; #1;
    check("R12", "pinOut follows portData", int'(pinOut), 0);

    // R2/R3/R6: modulo transmit, init low, low=3 high=5, routed, unmasked
    regWrite(2, 3);
    regWrite(3, 5);
    regWrite(1, 8'h01);
    regWrite(0, 8'h29);
    e0 = cyc;
    txModel(e0, 0, 3, 5, 24, 1, 0, 0, "R3", "R6");
    waitCyc(e0 + 25);
    regWrite(0, 8'h20);            // stop, status write 0
    readMask(0, 4, 4, "R5");       // status still set
    readMask(0, 1, 0, "R2");       // enable cleared by write
    regWrite(0, 8'h24);            // clear status
    readMask(0, 4, 0, "R5");

    // R7: ticks every other cycle, init high
    tickMode = 1;
    regWrite(1, 8'h03);
    regWrite(0, 8'h29);
    e0 = cyc;
    txModel(e0, 1, 3, 5, 30, 1, 1, 0, "R7", "R7");
    waitCyc(e0 + 31);
    regWrite(0, 8'h24);
    tickMode = 0;

    // R4: single pass, init high, high=2
    regWrite(3, 2);
    regWrite(0, 8'h2B);
    e0 = cyc;
    txModel(e0, 1, 3, 2, 14, 1, 0, 1, "R4", "R4");
    waitCyc(e0 + 15);
    readMask(0, 1, 0, "R4");
    readMask(0, 4, 4, "R5");
    regWrite(0, 8'h24);

    // R6: masked timeout interrupt, low=1 init low
    regWrite(2, 1);
    regWrite(1, 8'h01);
    regWrite(0, 8'h21);
    e0 = cyc;
    txModel(e0, 0, 1, 2, 10, 0, 0, 0, "R3", "R6");
    waitCyc(e0 + 11);
    regWrite(0, 8'h20);
    readMask(0, 4, 4, "R6");
    regWrite(0, 8'h24);

    // R8: demodulation, rising edges, no filter
    regWrite(2, 255);
    regWrite(3, 255);
    regWrite(1, 8'h04);
    regWrite(0, 8'h19);
    c0 = cyc + 3;
    waitCyc(c0); sigIn = 1'b1;
    expectAt(c0 + 2, 2, 0, "R8");          // first edge only arms
    waitCyc(c0 + 5); sigIn = 1'b0;
    expectAt(c0 + 7, 2, 0, "R9");          // falling edge ignored
    waitCyc(c0 + 40); sigIn = 1'b1;
    expectAt(c0 + 42, 2, 1, "R8");
    waitCyc(c0 + 44);
    readMask(4, 255, 216, "R8");
    // R11: quiet for 256 ticks after the last edge
    expectAt(c0 + 297, 1, 0, "R11");
    expectAt(c0 + 298, 1, 1, "R11");
    waitCyc(c0 + 300);
    readMask(0, 5, 5, "R11");              // still enabled, status set

    // R9: both edges
    regWrite(1, 8'h0C);
    c1 = cyc + 2;
    waitCyc(c1); sigIn = 1'b0;
    expectAt(c1 + 2, 2, 1, "R9");
    waitCyc(c1 + 10); sigIn = 1'b1;
    expectAt(c1 + 12, 2, 1, "R9");
    waitCyc(c1 + 14);
    readMask(4, 255, 246, "R9");

    // R10: filter width 3 rejects a 3-clock glitch
    regWrite(0, 8'h00);
    regWrite(1, 8'h34);
    sigIn = 1'b0;
    repeat (10) @(negedge clk);
    regWrite(0, 8'h11);
    c1 = cyc + 2;
    waitCyc(c1); sigIn = 1'b1;
    waitCyc(c1 + 3); sigIn = 1'b0;
    c2 = c1 + 10;
    waitCyc(c2); sigIn = 1'b1;
    expectAt(c2 + 2, 2, 0, "R10");
    expectAt(c2 + 5, 2, 0, "R10");
    waitCyc(c2 + 10); sigIn = 1'b0;
    waitCyc(c2 + 30); sigIn = 1'b1;
    expectAt(c2 + 35, 2, 1, "R10");
    waitCyc(c2 + 37);
    readMask(4, 255, 226, "R10");

    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      nBad++;
      $display("FAIL scoreboard: actual=%0d pending expected=0", sb.size());
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule